// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This unit takes an accepted interrupt or trap request and turns it into the 32-bit start address of its handler. It reads the four bytes of a vector one at a time through a synchronous byte-read port and assembles them. Fixed sources (reset, external non-maskable pin, undefined instruction, overflow trap, break instruction, address match, debugger) have constant vector addresses. Peripheral and software requests index a relocatable table of 64 four-byte entries, whose base comes from a table-base input.

A break instruction whose fixed vector is unprogrammed is redirected at run time. If the top byte of that vector reads as 0xFF, the unit discards it and fetches entry 0 of the relocatable table. The global enable flag gates only the relocatable requests. Requests that arrive while a fetch is under way are latched and served in priority order once the fetch ends. A reset request aborts any fetch at once.

Top module: `irq_vector_fetch`

## Requirements
- R1: A vector is read as four consecutive byte addresses, lowest first. The byte at the lowest address forms bits 7:0 and the byte at the highest forms bits 31:24. `rd_data` carries the byte for a read issued on the previous cycle.
- R2: The fixed vector addresses are fixed as follows:
  - undefined instruction: 0xFFFFDC
  - overflow: 0xFFFFE0
  - break: 0xFFFFE4
  - address match: 0xFFFFE8
  - non-maskable pin: 0xFFFFF8
  - reset: 0xFFFFFC
  - debugger: 0x000020
- R3: A relocatable request with number n (0 to 63) fetches from `tbase` + 4n. `tbase` is sampled when the fetch starts, so a later change has no effect on that fetch.
- R4: For a break request, if the byte read from 0xFFFFE7 is 0xFF, the unit reads the vector at `tbase` + 0 and delivers that vector instead.
- R5: An address-match pulse is ignored while `amatch_en` is 0. It causes no read and no result.
- R6: A relocatable request is not served while `gie` is 0. It stays pending and is served once `gie` becomes 1.
- R7: Debugger, non-maskable pin, undefined-instruction, overflow and break requests are served whether `gie` is 0 or 1.
- R8: Pending requests are served in this order: debugger, non-maskable pin, undefined, overflow, break, address match, relocatable. A request that arrives during a fetch is kept and served afterwards.
- R9: `reset_req` aborts any fetch in progress. The aborted fetch yields no result, and the reset vector is read starting in the next cycle.
- R10: `vec_valid` is high for exactly one cycle per completed fetch, together with the vector on `vec_out`. After `rst_n` no read is issued and `vec_valid` is 0 until a request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Reset source pulse, aborts current fetch |
| dbg_req | input | 1 | Debugger break / single-step pulse |
| nmi_req | input | 1 | Non-maskable pin request pulse |
| und_req | input | 1 | Undefined-instruction trap pulse |
| ovf_req | input | 1 | Overflow trap pulse |
| brk_req | input | 1 | Break-instruction trap pulse |
| amatch_req | input | 1 | Address-match request pulse |
| amatch_en | input | 1 | Enable for address-match source |
| rel_req | input | 1 | Relocatable-table request pulse |
| rel_num | input | 6 | Relocatable entry number |
| gie | input | 1 | Global interrupt enable |
| tbase | input | 24 | Relocatable table base address |
| rd_en | output | 1 | Byte read strobe |
| rd_addr | output | 24 | Byte read address |
| rd_data | input | 8 | Byte returned one cycle after the read |
| vec_valid | output | 1 | One-cycle result strobe |
| vec_out | output | 32 | Assembled handler address |

## Verification
The bench fires every source at the same moment and expects the results in strict priority order. A wrong priority encoder would reorder the scoreboard entries, and a lost pending bit would leave an entry unserved. It changes `tbase` while a relocatable fetch is under way and expects the old base, which catches a design that reads the live input. It runs a break request with the top byte both programmed and at 0xFF, so a missing fallback, or a fallback to the wrong entry, delivers a wrong vector. It also aborts a fetch midway with a reset request, sends address-match pulses while disabled, and sends relocatable pulses while masked. A design that leaked any of these would produce extra results or reads.

// File: rtl/irq_vector_fetch.sv
module irq_vector_fetch #(
  parameter int AW = 24,
  parameter int VW = 32,
  parameter int NW = 6,
  parameter logic [23:0] UND_VEC = 24'hFFFFDC,
  parameter logic [23:0] OVF_VEC = 24'hFFFFE0,
  parameter logic [23:0] BRK_VEC = 24'hFFFFE4,
  parameter logic [23:0] AM_VEC  = 24'hFFFFE8,
  parameter logic [23:0] NMI_VEC = 24'hFFFFF8,
  parameter logic [23:0] RST_VEC = 24'hFFFFFC,
  parameter logic [23:0] DBG_VEC = 24'h000020
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_req,
  input  logic          dbg_req,
  input  logic          nmi_req,
  input  logic          und_req,
  input  logic          ovf_req,
  input  logic          brk_req,
  input  logic          amatch_req,
  input  logic          amatch_en,
  input  logic          rel_req,
  input  logic [NW-1:0] rel_num,
  input  logic          gie,
  input  logic [AW-1:0] tbase,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          vec_valid,
  output logic [VW-1:0] vec_out
);
  localparam int NB = VW / 8;
  localparam int CW = $clog2(NB + 1);

  typedef enum logic [1:0] {IDLE, FETCH, DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cur, tb_q, start;
  logic          is_brk, fb, rel_pend, take_fix, take_rel, idle;
  logic [NW-1:0] num_q;
  logic [5:0]    pend, set, grant, clr;
  logic [VW-1:0] vec;

  // bit order is the service priority: dbg, nmi, und, ovf, brk, amatch
  assign set      = {amatch_req & amatch_en, brk_req, ovf_req, und_req, nmi_req, dbg_req};
  assign grant    = pend & (~pend + 6'd1);
  assign idle     = (st == IDLE) && !reset_req;
  assign take_fix = idle && (pend != 6'd0);
  assign take_rel = idle && (pend == 6'd0) && rel_pend && gie;
  assign clr      = take_fix ? grant : 6'd0;

  always_comb begin
    start = tbase + (AW'(num_q) << 2);
    if (grant[0])      start = AW'(DBG_VEC);
    else if (grant[1]) start = AW'(NMI_VEC);
    else if (grant[2]) start = AW'(UND_VEC);
    else if (grant[3]) start = AW'(OVF_VEC);
    else if (grant[4]) start = AW'(BRK_VEC);
    else if (grant[5]) start = AW'(AM_VEC);
  end

  assign rd_en     = (st == FETCH) && (cnt < CW'(NB));
  assign rd_addr   = cur + AW'(cnt);
  assign vec_valid = (st == DONE);
  assign vec_out   = vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; cur <= '0; tb_q <= '0; is_brk <= 1'b0; fb <= 1'b0;
      pend <= '0; rel_pend <= 1'b0; num_q <= '0; vec <= '0;
    end else begin
      pend <= (pend & ~clr) | set;
      if (rel_req) begin
        rel_pend <= 1'b1;
        num_q    <= rel_num;
      end else if (take_rel) begin
        rel_pend <= 1'b0;
      end
      if (reset_req) begin
        st <= FETCH; cur <= AW'(RST_VEC); cnt <= '0; is_brk <= 1'b0; fb <= 1'b0; tb_q <= tbase;
      end else begin
        case (st)
          IDLE: if (take_fix || take_rel) begin
            st <= FETCH; cur <= start; cnt <= '0; fb <= 1'b0; tb_q <= tbase;
            is_brk <= take_fix && grant[4];
          end
          FETCH: begin
            cnt <= cnt + 1'b1;
            if (cnt != '0) vec <= {rd_data, vec[VW-1:8]};
            if (cnt == CW'(NB)) begin
              if (is_brk && !fb && rd_data == 8'hFF) begin
                fb <= 1'b1; cur <= tb_q; cnt <= '0;
              end else begin
                st <= DONE;
              end
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  a_r1_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) && !$past(reset_req) |-> rd_addr == $past(rd_addr) + AW'(1));

  a_r9_reset_abort: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> rd_en && rd_addr == AW'(RST_VEC));

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);

  a_r10_no_read_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !rd_en);

  a_r6_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) && !gie && (pend == 6'd0) && !reset_req |=> !rd_en);

  a_r4_fallback_base: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb) && !$past(reset_req) |-> rd_en && rd_addr == tb_q);
endmodule

// File: tb/irq_vector_fetch_bench.sv
`timescale 1ns/100ps
module irq_vector_fetch_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reset_req = 0, dbg_req = 0, nmi_req = 0, und_req = 0, ovf_req = 0, brk_req = 0;
  logic amatch_req = 0, amatch_en = 0, rel_req = 0, gie = 0;
  logic [5:0] rel_num = '0;
  logic [23:0] tbase = 24'h004000;
  logic rd_en, vec_valid;
  logic [23:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic [31:0] vec_out;
  logic brk_unprog = 1'b0;
  int total = 0, bad = 0, valid_cnt = 0, rd_cnt = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic prev_valid = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_fetch u_irq_vector_fetch (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .dbg_req(dbg_req), .nmi_req(nmi_req),
    .und_req(und_req), .ovf_req(ovf_req), .brk_req(brk_req), .amatch_req(amatch_req),
    .amatch_en(amatch_en), .rel_req(rel_req), .rel_num(rel_num), .gie(gie), .tbase(tbase),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .vec_valid(vec_valid), .vec_out(vec_out));

  function automatic logic [7:0] mem_at(input logic [23:0] a);
    if (a == 24'hFFFFE7 && brk_unprog) return 8'hFF;
    return a[7:0] ^ {a[11:8], a[19:16]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] vec_at(input logic [23:0] a);
    return {mem_at(a + 24'd3), mem_at(a + 24'd2), mem_at(a + 24'd1), mem_at(a)};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= mem_at(rd_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_en) rd_cnt++;
    if (rst_n && vec_valid) begin
      valid_cnt++;
      check(!prev_valid, "R10", 32'(prev_valid), 32'd0);
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected result", vec_out, 32'hx);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vec_out === e, t, vec_out, e);
      end
    end
    prev_valid = rst_n && vec_valid;
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic idle_check(input string req);
    int v0, r0;
    v0 = valid_cnt; r0 = rd_cnt;
    repeat (20) @(negedge clk);
    check(valid_cnt == v0, req, 32'(valid_cnt), 32'(v0));
    check(rd_cnt == r0, req, 32'(rd_cnt), 32'(r0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!vec_valid && !rd_en, "R10 reset state", {30'd0, vec_valid, rd_en}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!vec_valid && !rd_en, "R10 after reset", {30'd0, vec_valid, rd_en}, 32'd0);

    // R2/R1: each fixed source alone
    push(vec_at(24'hFFFFDC), "R2 und"); und_req = 1; @(negedge clk); und_req = 0; drain();
    push(vec_at(24'hFFFFE0), "R2 ovf"); ovf_req = 1; @(negedge clk); ovf_req = 0; drain();
    push(vec_at(24'hFFFFE4), "R2 brk programmed"); brk_req = 1; @(negedge clk); brk_req = 0; drain();
    push(vec_at(24'hFFFFF8), "R2 nmi"); nmi_req = 1; @(negedge clk); nmi_req = 0; drain();
    push(vec_at(24'hFFFFFC), "R2 reset"); reset_req = 1; @(negedge clk); reset_req = 0; drain();
    push(vec_at(24'h000020), "R2 dbg"); dbg_req = 1; @(negedge clk); dbg_req = 0; drain();

    // R5: address match disabled then enabled
    amatch_en = 0; amatch_req = 1; @(negedge clk); amatch_req = 0;
    idle_check("R5");
    amatch_en = 1;
    push(vec_at(24'hFFFFE8), "R5 enabled"); amatch_req = 1; @(negedge clk); amatch_req = 0; drain();

    // R3: relocatable entries
    gie = 1;
    foreach (tbase[i]) if (i < 0) tbase = '0;
    tbase = 24'h004000; rel_num = 6'd0;
    push(vec_at(24'h004000), "R3 n=0"); rel_req = 1; @(negedge clk); rel_req = 0; drain();
    tbase = 24'h12A000; rel_num = 6'd63;
    push(vec_at(24'h12A000 + 24'd252), "R3 n=63"); rel_req = 1; @(negedge clk); rel_req = 0; drain();
    tbase = 24'h00F100; rel_num = 6'd9;
    push(vec_at(24'h00F100 + 24'd36), "R3 tbase sampled"); rel_req = 1; @(negedge clk); rel_req = 0;
    repeat (2) @(negedge clk);
    tbase = 24'h777700;
    drain();

    // R4: break fallback to table entry 0
    brk_unprog = 1; tbase = 24'h012340;
    push(vec_at(24'h012340), "R4 fallback"); brk_req = 1; @(negedge clk); brk_req = 0;
    repeat (2) @(negedge clk);
    tbase = 24'h0A0A00;
    drain();
    brk_unprog = 0;

    // R6/R7: masked relocatable held, non-maskables served
    gie = 0; tbase = 24'h003300; rel_num = 6'd7;
    rel_req = 1; @(negedge clk); rel_req = 0;
    idle_check("R6 masked");
    push(vec_at(24'hFFFFF8), "R7 nmi gie=0"); nmi_req = 1; @(negedge clk); nmi_req = 0; drain();
    push(vec_at(24'h000020), "R7 dbg gie=0"); dbg_req = 1; @(negedge clk); dbg_req = 0; drain();
    push(vec_at(24'hFFFFE0), "R7 ovf gie=0"); ovf_req = 1; @(negedge clk); ovf_req = 0; drain();
    push(vec_at(24'h003300 + 24'd28), "R6 released"); gie = 1; drain();

    // R8: all sources together
    tbase = 24'h0B0000; rel_num = 6'd63; amatch_en = 1;
    push(vec_at(24'h000020), "R8 dbg first");
    push(vec_at(24'hFFFFF8), "R8 nmi");
    push(vec_at(24'hFFFFDC), "R8 und");
    push(vec_at(24'hFFFFE0), "R8 ovf");
    push(vec_at(24'hFFFFE4), "R8 brk");
    push(vec_at(24'hFFFFE8), "R8 amatch");
    push(vec_at(24'h0B0000 + 24'd252), "R8 rel last");
    dbg_req = 1; nmi_req = 1; und_req = 1; ovf_req = 1; brk_req = 1; amatch_req = 1; rel_req = 1;
    @(negedge clk);
    dbg_req = 0; nmi_req = 0; und_req = 0; ovf_req = 0; brk_req = 0; amatch_req = 0; rel_req = 0;
    drain();

    // R8: request during busy fetch is held
    push(vec_at(24'hFFFFE0), "R8 busy first");
    push(vec_at(24'hFFFFDC), "R8 busy held");
    ovf_req = 1; @(negedge clk); ovf_req = 0;
    repeat (3) @(negedge clk);
    und_req = 1; @(negedge clk); und_req = 0;
    drain();

    // R9: reset aborts a fetch midway
    begin
      int v0;
      v0 = valid_cnt;
      push(vec_at(24'hFFFFFC), "R9 reset after abort");
      und_req = 1; @(negedge clk); und_req = 0;
      repeat (3) @(negedge clk);
      reset_req = 1; @(negedge clk); reset_req = 0;
      drain();
      check(valid_cnt == v0 + 1, "R9 single result", 32'(valid_cnt), 32'(v0 + 1));
    end

    check(exp_q.size() == 0, "R8 queue empty", 32'(exp_q.size()), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule